// File: doc/BRIEF.md
# Task Memory Protection Unit

This block sits between a processor's access port and the system bus. It screens each bus access against eight address windows that software sets up for the task that is running. Every window has its own enable bit, a write-protect bit and an execute-protect bit. Windows are compared on 8-byte blocks, so the three lowest address bits never take part in a match. An access in the supervisor state is never screened. A user-state access reaches the bus only when at least one enabled window that covers it allows that kind of access. Every other user access is aborted.

The access side uses valid/ready. An access that passes is forwarded on the bus side in the same cycle, and the bus side's ready becomes the access side's ready, so back-pressure from the bus holds the access in place. An aborted access is never forwarded. It is consumed at once, whatever the bus is doing. One cycle after an access is aborted, the block raises a one-cycle non-maskable violation pulse. It also records the address and kind of the first faulting access and keeps them until software clears the fault flag. Windows are loaded one at a time through a simple write port.

Top module: `task_mpu`

## Requirements
- R1: When `acc_super` is 1, an access is never aborted, whatever its address, its kind or the window settings.
- R2: Access kinds are encoded on `acc_kind` as 00 read, 01 write, 10 fetch, and 11 is treated as a read. A user read passes if and only if some enabled window satisfies lo <= `acc_addr[AW-1:3]` <= hi, with both bounds inclusive and the three low address bits ignored.
- R3: A user write passes only if a covering enabled window has its write-protect bit at 0. When windows overlap, one permitting window is enough.
- R4: A user fetch passes only if a covering enabled window has its execute-protect bit at 0. When windows overlap, one permitting window is enough.
- R5: A user access that no enabled window covers is aborted, whatever its kind.
- R6: In the cycle an access is aborted, `acc_abort` is 1, `bus_valid` is 0 (the write or fetch is suppressed) and `acc_ready` is 1, whatever `bus_ready` is.
- R7: For an access that passes, `bus_valid` equals `acc_valid`, `acc_ready` follows `bus_ready`, and `acc_abort` is 0. When `acc_valid` is 0, both `bus_valid` and `acc_abort` are 0.
- R8: `viol_nmi` is high for exactly the one cycle that follows each cycle with an aborted access, and is low otherwise.
- R9: The first aborted access while `flt_valid` is 0 sets `flt_valid` and loads `flt_addr` (full address) and `flt_kind`. Later faults leave these unchanged until `flt_clear` is pulsed, which drops `flt_valid` the next cycle. A fault in the same cycle as the clear is captured.
- R10: A cycle with `cfg_we` high writes lo, hi, enable, write-protect and execute-protect into window `cfg_idx`. The new values take effect from the next cycle. After reset, all windows are disabled and no fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access consumed this cycle |
| acc_addr | input | AW | Access byte address |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_super | input | 1 | 1 = supervisor state, 0 = user state |
| acc_abort | output | 1 | Access denied this cycle |
| bus_valid | output | 1 | Forwarded access to bus |
| bus_ready | input | 1 | Bus accepts forwarded access |
| viol_nmi | output | 1 | One-cycle non-maskable violation pulse |
| flt_valid | output | 1 | A fault is held |
| flt_addr | output | AW | Address of held fault |
| flt_kind | output | 2 | Kind of held fault |
| flt_clear | input | 1 | Release the held fault |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | IW | Window index |
| cfg_lo | input | AW-3 | Lower block bound (inclusive) |
| cfg_hi | input | AW-3 | Upper block bound (inclusive) |
| cfg_en | input | 1 | Window enable |
| cfg_nw | input | 1 | Write-protect |
| cfg_nx | input | 1 | Execute-protect |

## Verification
Several properties are checked on every cycle: the supervisor bypass, the relation between the handshake signals and aborts (suppression of the forwarded access and immediate consumption), the timing of the one-cycle violation pulse, and that a held fault stays frozen while no clear arrives. Other behaviour needs the bench's scenarios and its reference model, because it depends on window contents that no single-cycle property can see. This covers the inclusive bounds, ignoring the low address bits, permission resolution across overlapping windows, which fault gets captured first, and the time at which a window load takes effect.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RDALT = 2'b11
  } acc_kind_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mpu_window_bank.sv
module mpu_window_bank #(
  parameter int NREG = 8,
  parameter int BW   = 21,
  parameter int IW   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IW-1:0]             cfg_idx,
  input  logic [BW-1:0]             cfg_lo,
  input  logic [BW-1:0]             cfg_hi,
  input  logic                      cfg_en,
  input  logic                      cfg_nw,
  input  logic                      cfg_nx,
  output logic [NREG-1:0][BW-1:0]   lo_q,
  output logic [NREG-1:0][BW-1:0]   hi_q,
  output logic [NREG-1:0]           en_q,
  output logic [NREG-1:0]           nw_q,
  output logic [NREG-1:0]           nx_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic sel;
    assign sel = cfg_we && (cfg_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
        en_q[g] <= 1'b0;
        nw_q[g] <= 1'b0;
        nx_q[g] <= 1'b0;
      end else if (sel) begin
        lo_q[g] <= cfg_lo;
        hi_q[g] <= cfg_hi;
        en_q[g] <= cfg_en;
        nw_q[g] <= cfg_nw;
        nx_q[g] <= cfg_nx;
      end
    end
  end
endmodule

// File: rtl/mpu_window_cmp.sv
module mpu_window_cmp
  import mpu_pkg::*;
#(
  parameter int BW = 21
) (
  input  logic [BW-1:0] blk,
  input  logic [BW-1:0] lo,
  input  logic [BW-1:0] hi,
  input  logic          en,
  input  logic          nw,
  input  logic          nx,
  input  logic [1:0]    kind,
  output logic          hit,
  output logic          permit
);
  logic kind_ok;
  always_comb begin
    hit = en && (blk >= lo) && (blk <= hi);
    case (kind)
      KIND_WRITE: kind_ok = !nw;
      KIND_FETCH: kind_ok = !nx;
      default:    kind_ok = 1'b1;
    endcase
    permit = hit && kind_ok;
  end
endmodule

// File: rtl/mpu_fault_latch.sv
module mpu_fault_latch #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol_evt,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    kind,
  input  logic          clear,
  output logic          nmi,
  output logic          held,
  output logic [AW-1:0] held_addr,
  output logic [1:0]    held_kind
);
  logic take;
  assign take = viol_evt && (!held || clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi       <= 1'b0;
      held      <= 1'b0;
      held_addr <= '0;
      held_kind <= 2'b00;
    end else begin
      nmi <= viol_evt;
      if (take) begin
        held      <= 1'b1;
        held_addr <= addr;
        held_kind <= kind;
      end else if (clear) begin
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/task_mpu.sv
module task_mpu
  import mpu_pkg::*;
#(
  parameter int AW        = 24,
  parameter int NREG      = 8,
  parameter int GRAN_BITS = 3,
  localparam int BW       = AW - GRAN_BITS,
  localparam int IW       = idx_width(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic          acc_super,
  output logic          acc_abort,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          viol_nmi,
  output logic          flt_valid,
  output logic [AW-1:0] flt_addr,
  output logic [1:0]    flt_kind,
  input  logic          flt_clear,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [BW-1:0] cfg_lo,
  input  logic [BW-1:0] cfg_hi,
  input  logic          cfg_en,
  input  logic          cfg_nw,
  input  logic          cfg_nx
);
  logic [NREG-1:0][BW-1:0] lo_q, hi_q;
  logic [NREG-1:0]         en_q, nw_q, nx_q;
  logic [NREG-1:0]         hit_v, permit_v;
  logic [BW-1:0]           blk;
  logic                    allowed;

  assign blk = acc_addr[AW-1:GRAN_BITS];

  mpu_window_bank #(.NREG(NREG), .BW(BW), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_en(cfg_en), .cfg_nw(cfg_nw), .cfg_nx(cfg_nx),
    .lo_q(lo_q), .hi_q(hi_q), .en_q(en_q), .nw_q(nw_q), .nx_q(nx_q)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    mpu_window_cmp #(.BW(BW)) u_cmp (
      .blk(blk), .lo(lo_q[g]), .hi(hi_q[g]), .en(en_q[g]),
      .nw(nw_q[g]), .nx(nx_q[g]), .kind(acc_kind),
      .hit(hit_v[g]), .permit(permit_v[g])
    );
  end

  assign allowed   = acc_super || (|permit_v);
  assign acc_abort = acc_valid && !allowed;
  assign bus_valid = acc_valid && allowed;
  assign acc_ready = allowed ? bus_ready : 1'b1;

  mpu_fault_latch #(.AW(AW)) u_flt (
    .clk(clk), .rst_n(rst_n),
    .viol_evt(acc_abort), .addr(acc_addr), .kind(acc_kind), .clear(flt_clear),
    .nmi(viol_nmi), .held(flt_valid), .held_addr(flt_addr), .held_kind(flt_kind)
  );

  logic unused_hits;
  assign unused_hits = ^hit_v;
endmodule

// File: rtl/task_mpu_checker.sv
module task_mpu_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic          acc_super,
  input logic          acc_abort,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          viol_nmi,
  input logic          flt_valid,
  input logic [AW-1:0] flt_addr,
  input logic [1:0]    flt_kind,
  input logic          flt_clear
);
  assert_super_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_super) |-> !acc_abort);

  assert_abort_suppress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |-> (!bus_valid && acc_ready));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!bus_valid && !acc_abort));

  assert_pass_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (acc_ready == bus_ready));

  assert_nmi_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |=> viol_nmi);

  assert_nmi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_abort |=> !viol_nmi);

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clear) |=> (flt_valid && $stable(flt_addr) && $stable(flt_kind)));

  assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |=> flt_valid);
endmodule

bind task_mpu task_mpu_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_super(acc_super), .acc_abort(acc_abort), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .viol_nmi(viol_nmi), .flt_valid(flt_valid),
  .flt_addr(flt_addr), .flt_kind(flt_kind), .flt_clear(flt_clear)
);

// File: tb/task_mpu_test.sv
`timescale 1ns/1ps
module task_mpu_test;
  localparam int AW = 24;
  localparam int NREG = 8;
  localparam int BW = AW - 3;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_super = 0, bus_ready = 0, flt_clear = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_kind = 0;
  logic cfg_we = 0, cfg_en = 0, cfg_nw = 0, cfg_nx = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [BW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic acc_ready, acc_abort, bus_valid, viol_nmi, flt_valid;
  logic [AW-1:0] flt_addr;
  logic [1:0] flt_kind;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [BW-1:0] m_lo [NREG];
  logic [BW-1:0] m_hi [NREG];
  bit m_en [NREG], m_nw [NREG], m_nx [NREG];
  bit m_fv = 0;
  logic [AW-1:0] m_fa = '0;
  logic [1:0] m_fk = 0;

  always #2 clk = ~clk;

  task_mpu uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_super(acc_super),
    .acc_abort(acc_abort), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .viol_nmi(viol_nmi), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_kind(flt_kind), .flt_clear(flt_clear), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_en(cfg_en),
    .cfg_nw(cfg_nw), .cfg_nx(cfg_nx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_pass(input logic [AW-1:0] a, input logic [1:0] k, input bit sup);
    bit ok = sup;
    for (int i = 0; i < NREG; i++) begin
      if (m_en[i] && a[AW-1:3] >= m_lo[i] && a[AW-1:3] <= m_hi[i]) begin
        if (k == 2'b01) ok |= !m_nw[i];
        else if (k == 2'b10) ok |= !m_nx[i];
        else ok = 1;
      end
    end
    return ok;
  endfunction

  task automatic load(input int idx, input int lo, input int hi, input bit en, input bit nw, input bit nx);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_lo = BW'(lo); cfg_hi = BW'(hi);
    cfg_en = en; cfg_nw = nw; cfg_nx = nx;
    @(negedge clk);
    cfg_we = 0;
    m_lo[idx] = BW'(lo); m_hi[idx] = BW'(hi); m_en[idx] = en; m_nw[idx] = nw; m_nx[idx] = nx;
  endtask

  task automatic clear_fault();
    @(negedge clk);
    flt_clear = 1;
    @(negedge clk);
    flt_clear = 0;
    m_fv = 0;
    check("R9 clear", 32'(flt_valid), 0);
  endtask

  task automatic access(input string req, input logic [AW-1:0] a, input logic [1:0] k,
                        input bit sup, input bit br);
    bit p;
    p = exp_pass(a, k, sup);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_kind = k; acc_super = sup; bus_ready = br;
    #1;
    check({req, " abort"}, 32'(acc_abort), 32'(!p));
    check({req, " R6/R7 bus_valid"}, 32'(bus_valid), 32'(p));
    check({req, " R6/R7 ready"}, 32'(acc_ready), p ? 32'(br) : 1);
    if (!p && !m_fv) begin m_fv = 1; m_fa = a; m_fk = k; end
    @(negedge clk);
    acc_valid = 0;
    check({req, " R8 nmi"}, 32'(viol_nmi), 32'(!p));
    check({req, " R9 flt_valid"}, 32'(flt_valid), 32'(m_fv));
    if (m_fv) begin
      check({req, " R9 flt_addr"}, 32'(flt_addr), 32'(m_fa));
      check({req, " R9 flt_kind"}, 32'(flt_kind), 32'(m_fk));
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < NREG; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_en[i] = 0; m_nw[i] = 0; m_nx[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset flt_valid", 32'(flt_valid), 0);
    check("R10 reset nmi", 32'(viol_nmi), 0);
    check("R7 idle bus_valid", 32'(bus_valid), 0);

    access("R5 R10 no window read", 24'h000080, 2'b00, 0, 1);
    clear_fault();

    load(0, 'h10, 'h1F, 1, 1, 0);
    access("R2 low edge", 24'h000080, 2'b00, 0, 1);
    access("R2 high edge low bits", 24'h0000FF, 2'b00, 0, 1);
    access("R2 above", 24'h000100, 2'b00, 0, 1);
    access("R2 below", 24'h00007F, 2'b00, 0, 1);
    access("R9 second fault held", 24'h000100, 2'b10, 0, 1);
    clear_fault();
    access("R3 write protected", 24'h000088, 2'b01, 0, 1);
    clear_fault();

    load(1, 'h18, 'h30, 1, 0, 1);
    access("R3 overlap write pass", 24'h0000C0, 2'b01, 0, 1);
    access("R4 fetch pass", 24'h000090, 2'b10, 0, 1);
    access("R4 overlap fetch pass", 24'h0000C0, 2'b10, 0, 1);
    access("R4 fetch protected", 24'h000100, 2'b10, 0, 1);
    access("R2 kind 11 read", 24'h000100, 2'b11, 0, 1);
    access("R1 super anywhere", 24'h001000, 2'b01, 1, 1);
    access("R1 super fetch", 24'h000100, 2'b10, 1, 0);
    access("R7 backpressure", 24'h000090, 2'b00, 0, 0);
    access("R6 abort no bus ready", 24'h002000, 2'b01, 0, 0);

    @(negedge clk);
    flt_clear = 1; acc_valid = 1; acc_addr = 24'h003008; acc_kind = 2'b10; acc_super = 0;
    @(negedge clk);
    flt_clear = 0; acc_valid = 0;
    check("R9 capture with clear addr", 32'(flt_addr), 32'h003008);
    check("R9 capture with clear valid", 32'(flt_valid), 1);
    m_fv = 1; m_fa = 24'h003008; m_fk = 2'b10;
    clear_fault();

    load(0, 'h10, 'h1F, 0, 0, 0);
    access("R10 disabled window", 24'h000090, 2'b00, 0, 1);
    clear_fault();

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      if (n % 40 == 0) begin
        int lo, hi;
        lo = int'($urandom_range(0, 100));
        hi = lo + int'($urandom_range(0, 30));
        load(int'($urandom_range(0, NREG - 1)), lo, hi, $urandom_range(0, 3) != 0,
             1'($urandom), 1'($urandom));
      end
      a = AW'($urandom_range(0, 1100));
      access("R2-R8 random", a, 2'($urandom), $urandom_range(0, 7) == 0, 1'($urandom));
      if ($urandom_range(0, 9) == 0) clear_fault();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule